// File: doc/BRIEF.md
# GPIO Port with Routed Interrupts

This block is a word-addressed general purpose I/O port of up to 32 lines. Software writes an output value and a direction per line, and reads back the pins after a two-flop synchroniser. Each line can be set up as an interrupt source with one of four trigger modes: active-low level, active-high level, falling edge or rising edge.

A per-line 8-bit routing field connects every line to one of several interrupt outputs, or to none. Each interrupt output is the OR of all enabled, triggered lines routed to it. Level triggers stay asserted while the level holds. Edge triggers give a pulse one clock long.

The register port writes on a clock edge when select and write are both high. Reads are combinational from the address. Register words travel on the bus byte-reversed, which is big-endian byte order.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, the output, direction, enable, polarity and trigger-type registers read 0, every routing field reads 0xFF, and all irq outputs are low.
- R2: Register byte addresses are 0x00 sampled pins (read-only), 0x04 output value, 0x08 direction, 0x0C interrupt enable, 0x10 polarity, 0x14 trigger type (1 = edge). Register bit i belongs to line i. Bits at or above NLINES read 0. Any other address, 0x18 included, reads 0 and ignores writes.
- R3: Bus data is byte-reversed against the register word. Register bits 31:24 travel on bus bits 7:0, and register bits 7:0 travel on bus bits 31:24.
- R4: pin_oe[i] equals direction bit i, and pin_out[i] equals output bit i, from the clock edge that writes them.
- R5: A change on pin_in shows in the 0x00 read value two clock edges later.
- R6: With trigger type 0, a line is triggered while its synchronised pin equals its polarity bit (0 = active low, 1 = active high).
- R7: With trigger type 1, a line triggers for exactly one cycle, on the second clock edge after the pin moves to the polarity level (0 = falling, 1 = rising). A move the other way triggers nothing.
- R8: A triggered line reaches no irq output while its enable bit is 0.
- R9: Line i has a routing field at register bits 8*(i%4)+7 to 8*(i%4) of the word at 0x20+4*(i/4). Bits 4:0 of the field give the output index and bits 7:5 are ignored. The value 0xFF, or an index of NIRQ or more, routes the line nowhere.
- R10: Each irq output is the OR of every enabled, triggered line routed to it. Several lines may share one output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, used together with bus_sel |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data, byte-reversed |
| bus_rdata | output | 32 | Read data, byte-reversed |
| pin_in | input | NLINES | Pin levels from the pads |
| pin_out | output | NLINES | Output levels to the pads |
| pin_oe | output | NLINES | Output enable to the pads |
| irq | output | NIRQ | Routed interrupt outputs |

## Verification
The assertions assume that pin_in carries no unknown values and that a register write occurs only when bus_sel and bus_wr are high together. The synchroniser assertion assumes that nothing about pin_in before reset matters. It therefore waits three edges after reset before it compares the synchronised value with pin_in. The bench holds the pins at 0 during reset and changes pins and bus signals only on falling clock edges. After each reconfiguration it waits for the synchroniser to settle before it compares irq.

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
  parameter int NLINES = 32,
  parameter int NIRQ   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic [NIRQ-1:0]   irq
);
  localparam int NMAPW = (NLINES + 3) / 4;

  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  logic [NLINES-1:0] out_r, dir_r, en_r, pol_r, typ_r;
  logic [NLINES-1:0] s1, s2, s3;
  logic [7:0]        map_r [NLINES];
  logic [31:0]       rreg;
  logic [1:0]        age;

  wire        wen  = bus_sel & bus_wr;
  wire [31:0] wreg = bswap(bus_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_r <= '0; dir_r <= '0; en_r <= '0; pol_r <= '0; typ_r <= '0;
      s1 <= '0; s2 <= '0; s3 <= '0;
      for (int i = 0; i < NLINES; i++) map_r[i] <= 8'hFF;
    end else begin
      s1 <= pin_in; s2 <= s1; s3 <= s2;
      if (wen) begin
        case (bus_addr)
          8'h04: out_r <= wreg[NLINES-1:0];
          8'h08: dir_r <= wreg[NLINES-1:0];
          8'h0C: en_r  <= wreg[NLINES-1:0];
          8'h10: pol_r <= wreg[NLINES-1:0];
          8'h14: typ_r <= wreg[NLINES-1:0];
          default: ;
        endcase
        for (int i = 0; i < NLINES; i++)
          if (bus_addr == 8'(32 + 4 * (i / 4))) map_r[i] <= wreg[8*(i%4) +: 8];
      end
    end
  end

  always_comb begin
    rreg = '0;
    case (bus_addr)
      8'h00: rreg = 32'(s2);
      8'h04: rreg = 32'(out_r);
      8'h08: rreg = 32'(dir_r);
      8'h0C: rreg = 32'(en_r);
      8'h10: rreg = 32'(pol_r);
      8'h14: rreg = 32'(typ_r);
      default:
        for (int i = 0; i < NLINES; i++)
          if (bus_addr == 8'(32 + 4 * (i / 4))) rreg[8*(i%4) +: 8] = map_r[i];
    endcase
  end
  assign bus_rdata = bswap(rreg);

  assign pin_out = out_r;
  assign pin_oe  = dir_r;

  wire [NLINES-1:0] lvl = ~(s2 ^ pol_r);
  wire [NLINES-1:0] edg = (s2 ^ s3) & lvl;
  wire [NLINES-1:0] act = ((typ_r & edg) | (~typ_r & lvl)) & en_r;

  always_comb begin
    irq = '0;
    for (int k = 0; k < NIRQ; k++)
      for (int i = 0; i < NLINES; i++)
        if (map_r[i] != 8'hFF && map_r[i][4:0] == 5'(k)) irq[k] = irq[k] | act[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_out_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && bus_addr == 8'h04) |=> pin_out == $past(wreg[NLINES-1:0]));
  p_dir_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && bus_addr == 8'h08) |=> pin_oe == $past(wreg[NLINES-1:0]));
  p_sample_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> s2 == $past(pin_in, 2));
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_r == '0) |-> irq == '0);
  p_ignored_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && bus_addr == 8'h18) |=> $stable(pin_out) && $stable(pin_oe));
  initial NMAPW_check: assert (NMAPW >= 1 && NLINES <= 32 && NIRQ <= 32);
endmodule

// File: tb/sim_gpio_irq_router.sv
`timescale 1ns/1ps
module sim_gpio_irq_router;
  localparam int NL = 8;
  localparam int NI = 3;

  logic clk = 0, rst_n = 0, bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NL-1:0] pin_in = '0, pin_out, pin_oe;
  logic [NI-1:0] irq;
  int vectors = 0, miscompares = 0;

  always #2 clk = ~clk;

  gpio_irq_router #(.NLINES(NL), .NIRQ(NI)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  function automatic logic [31:0] rev(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = rev(v);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = rev(bus_rdata);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    step(1);
    // R1 reset state
    for (int a = 4; a <= 20; a += 4) begin rd(8'(a), v); chk("R1 reg reset", v, 0); end
    rd(8'h20, v); chk("R1 map0 reset", v, 32'hFFFFFFFF);
    rd(8'h24, v); chk("R1 map1 reset", v, 32'hFFFFFFFF);
    chk("R1 irq reset", 32'(irq), 0);
    chk("R1 oe reset", 32'(pin_oe), 0);
    // R2 R4 R3
    wr(8'h04, 32'hFFFFFFA5);
    wr(8'h08, 32'h0000003C);
    chk("R4 pin_out", 32'(pin_out), 32'hA5);
    chk("R4 pin_oe", 32'(pin_oe), 32'h3C);
    rd(8'h04, v); chk("R2 out readback upper zero", v, 32'hA5);
    #1 chk("R3 byte lanes", bus_rdata, 32'hA5000000);
    wr(8'h18, 32'hFFFFFFFF);
    rd(8'h18, v); chk("R2 unmapped reads zero", v, 0);
    chk("R2 unmapped write no effect out", 32'(pin_out), 32'hA5);
    chk("R2 unmapped write no effect oe", 32'(pin_oe), 32'h3C);
    rd(8'h28, v); chk("R2 beyond map reads zero", v, 0);
    wr(8'h10, 32'h5A);
    rd(8'h10, v); chk("R2 polarity readback", v, 32'h5A);
    wr(8'h10, 0);
    // R5 sampling delay
    pin_in = 8'h96;
    rd(8'h00, v); chk("R5 before edge", v, 0);
    step(1); rd(8'h00, v); chk("R5 one edge", v, 0);
    step(1); rd(8'h00, v); chk("R5 two edges", v, 32'h96);
    pin_in = 8'h00;

    // R6 R7 R8 R9 sweep
    for (int ln = 0; ln < NL; ln++)
      for (int md = 0; md < 4; md++)
        for (int ti = 0; ti < 6; ti++)
          for (int en = 0; en < 2; en++) begin
            logic [7:0] tgt;
            logic [31:0] w0, w1, expv;
            logic pol, typ;
            logic [NL-1:0] inact;
            tgt = (ti == 0) ? 8'h00 : (ti == 1) ? 8'h01 : (ti == 2) ? 8'h02 :
                  (ti == 3) ? 8'h21 : (ti == 4) ? 8'h03 : 8'hFF;
            pol = md[0]; typ = md[1];
            inact = pol ? '0 : '1;
            expv = 0;
            if (en == 1 && tgt != 8'hFF && int'(tgt[4:0]) < NI) expv = 32'(1) << tgt[4:0];
            pin_in = inact;
            w0 = 32'hFFFFFFFF; w1 = 32'hFFFFFFFF;
            if (ln < 4) w0[8*(ln%4) +: 8] = tgt; else w1[8*(ln%4) +: 8] = tgt;
            wr(8'h0C, en ? 32'(1) << ln : 0);
            wr(8'h10, pol ? 32'(1) << ln : 0);
            wr(8'h14, typ ? 32'(1) << ln : 0);
            wr(8'h20, w0);
            wr(8'h24, w1);
            step(3);
            chk("R6 R7 idle before trigger", 32'(irq), 0);
            pin_in[ln] = ~inact[ln];
            if (!typ) begin
              step(3); chk("R6 R8 R9 level active", 32'(irq), expv);
              pin_in[ln] = inact[ln];
              step(3); chk("R6 level released", 32'(irq), 0);
            end else begin
              step(1); chk("R7 one edge after", 32'(irq), 0);
              step(1); chk("R7 R8 R9 edge pulse", 32'(irq), expv);
              step(1); chk("R7 pulse single cycle", 32'(irq), 0);
              pin_in[ln] = inact[ln];
              for (int c = 0; c < 3; c++) begin step(1); chk("R7 opposite edge ignored", 32'(irq), 0); end
            end
          end

    // R10 sharing
    pin_in = '0;
    wr(8'h0C, 32'h26);
    wr(8'h10, 32'hFF);
    wr(8'h14, 32'h00);
    wr(8'h20, 32'hFF00_02FF);
    wr(8'h24, 32'hFFFF_02FF);
    step(3); chk("R10 none high", 32'(irq), 0);
    pin_in = 8'h02; step(3); chk("R10 line1 alone", 32'(irq), 32'h4);
    pin_in = 8'h20; step(3); chk("R10 line5 alone", 32'(irq), 32'h4);
    pin_in = 8'h22; step(3); chk("R10 both shared", 32'(irq), 32'h4);
    pin_in = 8'h26; step(3); chk("R10 plus line2 on irq0", 32'(irq), 32'h5);
    pin_in = 8'h04; step(3); chk("R10 line2 alone", 32'(irq), 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule